// File: doc/BRIEF.md
# Spike-Count Winner Decoder

This block sits at the output layer of a spiking classifier. A classification window is a run of slot cycles. In each slot the block receives one bit for each output neuron, and a set bit means that neuron fired in that slot. One counter per neuron adds up that neuron's firings from the slot that opens the window through the slot that closes it.

When the window closes, the block picks the neuron with the largest count and reports its index together with that count. It also reports which of three outcomes occurred: a single clear winner, a shared maximum, or a window in which no neuron fired at all. A downstream consumer can then tell an ambiguous result from a silent one.

The result appears one cycle after the closing slot, marked by a one-cycle strobe. It stays on the outputs until the next window closes.

Top module: `spike_winner_decoder`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `result_valid`, `tie_flag` and `no_spike` are 0, and `class_idx` and `win_count` are 0.
- R2: A slot is counted when `win_start` is high or a window is open. A window opens with `win_start` and closes after the slot in which `win_end` is high, and both of those slots count. `win_count` reports the winner's number of set spike bits over the window.
- R3: `class_idx` is the index of the neuron with the strictly highest count. Neuron k is bit k of `spikes`.
- R4: When two or more neurons share a nonzero maximum, `class_idx` is the lowest of those indices and `tie_flag` is 1. Otherwise `tie_flag` is 0.
- R5: When every count is zero, `no_spike` is 1, `class_idx` is 0, `win_count` is 0 and `tie_flag` is 0. Otherwise `no_spike` is 0.
- R6: Each counter saturates at 2^CNT_W-1 and never wraps, however long the window lasts.
- R7: `result_valid` is high for exactly one cycle: the cycle after a slot that closes a window. The result outputs keep their values until the next window closes.
- R8: Spike bits seen while no window is open have no effect on any count. A `win_end` while no window is open produces no result.
- R9: `win_start` and `win_end` high in the same cycle form a window of one slot.
- R10: A `win_start` while a window is already open discards the counts so far and restarts the window, counting that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_start | input | 1 | First slot of a window |
| win_end | input | 1 | Last slot of a window |
| spikes | input | NUM_NEURONS | Firing bits for the current slot |
| result_valid | output | 1 | One-cycle strobe for a new result |
| class_idx | output | $clog2(NUM_NEURONS) | Winning neuron index |
| win_count | output | CNT_W | Count of the winning neuron |
| tie_flag | output | 1 | Shared nonzero maximum |
| no_spike | output | 1 | No neuron fired in the window |

## Verification
The bench builds the block with its defaults: ten neurons and 8-bit counters. Most windows last 128 slots, so a neuron that fires in every slot reaches 128 without wrapping. One directed window lasts 300 slots, which drives the counters into saturation at 255 without changing any parameter. Short windows cover the remaining cases: the one-slot window, a restarted window, and spikes or window ends that arrive while no window is open.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    VERDICT_UNIQUE = 2'd0,
    VERDICT_TIE    = 2'd1,
    VERDICT_SILENT = 2'd2
  } verdict_e;
endpackage

// File: rtl/swd_lane_counter.sv
module swd_lane_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  input  logic             spike,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  always_comb begin
    if (clear)
      cnt_next = {{(CNT_W-1){1'b0}}, spike};
    else if (count_en && spike)
      cnt_next = bump(cnt_q);
    else
      cnt_next = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end
endmodule

// File: rtl/swd_winner_pick.sv
module swd_winner_pick
  import swd_pkg::*;
#(
  parameter int NUM_NEURONS = 10,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = $clog2(NUM_NEURONS)
) (
  input  logic [NUM_NEURONS*CNT_W-1:0] counts,
  output logic [IDX_W-1:0]             best_idx,
  output logic [CNT_W-1:0]             best_cnt,
  output verdict_e                     verdict
);
  logic seen;
  logic dup;

  always_comb begin
    best_idx = '0;
    best_cnt = counts[0 +: CNT_W];
    for (int i = 1; i < NUM_NEURONS; i++) begin
      if (counts[i*CNT_W +: CNT_W] > best_cnt) begin
        best_cnt = counts[i*CNT_W +: CNT_W];
        best_idx = IDX_W'(i);
      end
    end
    seen = 1'b0;
    dup  = 1'b0;
    for (int i = 0; i < NUM_NEURONS; i++) begin
      if (counts[i*CNT_W +: CNT_W] == best_cnt) begin
        dup  = dup | seen;
        seen = 1'b1;
      end
    end
    if (best_cnt == '0)  verdict = VERDICT_SILENT;
    else if (dup)        verdict = VERDICT_TIE;
    else                 verdict = VERDICT_UNIQUE;
  end
endmodule

// File: rtl/spike_winner_decoder.sv
module spike_winner_decoder
  import swd_pkg::*;
#(
  parameter int NUM_NEURONS = 10,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = $clog2(NUM_NEURONS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_start,
  input  logic                   win_end,
  input  logic [NUM_NEURONS-1:0] spikes,
  output logic                   result_valid,
  output logic [IDX_W-1:0]       class_idx,
  output logic [CNT_W-1:0]       win_count,
  output logic                   tie_flag,
  output logic                   no_spike
);
  logic                         win_open;
  logic                         slot_live;
  logic                         close_evt;
  logic [NUM_NEURONS*CNT_W-1:0] lane_cnt;
  logic [NUM_NEURONS*CNT_W-1:0] lane_next;
  logic [IDX_W-1:0]             pick_idx;
  logic [CNT_W-1:0]             pick_cnt;
  verdict_e                     pick_verdict;

  assign slot_live = win_start | win_open;
  assign close_evt = win_end & slot_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_open <= 1'b0;
    else if (win_end)    win_open <= 1'b0;
    else if (win_start)  win_open <= 1'b1;
  end

  for (genvar g = 0; g < NUM_NEURONS; g++) begin : g_lane
    swd_lane_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (win_start),
      .count_en (win_open),
      .spike    (spikes[g]),
      .cnt_q    (lane_cnt[g*CNT_W +: CNT_W]),
      .cnt_next (lane_next[g*CNT_W +: CNT_W])
    );
  end

  swd_winner_pick #(.NUM_NEURONS(NUM_NEURONS), .CNT_W(CNT_W)) u_pick (
    .counts   (lane_next),
    .best_idx (pick_idx),
    .best_cnt (pick_cnt),
    .verdict  (pick_verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      class_idx    <= '0;
      win_count    <= '0;
      tie_flag     <= 1'b0;
      no_spike     <= 1'b0;
    end else begin
      result_valid <= close_evt;
      if (close_evt) begin
        class_idx <= pick_idx;
        win_count <= pick_cnt;
        tie_flag  <= (pick_verdict == VERDICT_TIE);
        no_spike  <= (pick_verdict == VERDICT_SILENT);
      end
    end
  end
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int NUM_NEURONS = 10,
  parameter int CNT_W       = 8,
  localparam int IDX_W      = $clog2(NUM_NEURONS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         win_start,
  input logic                         win_end,
  input logic                         win_open,
  input logic                         result_valid,
  input logic [IDX_W-1:0]             class_idx,
  input logic [CNT_W-1:0]             win_count,
  input logic                         tie_flag,
  input logic                         no_spike,
  input logic [NUM_NEURONS*CNT_W-1:0] lane_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r7_strobe_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && (win_open || win_start)) |=> result_valid);

  a_r8_no_strobe_without_close: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_end && (win_open || win_start)) |=> !result_valid);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(class_idx) && $stable(win_count) && $stable(tie_flag) && $stable(no_spike)));

  a_r5_silent_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    no_spike |-> (class_idx == '0 && win_count == '0 && !tie_flag));

  a_r5_count_implies_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (win_count != '0) |-> !no_spike);

  for (genvar g = 0; g < NUM_NEURONS; g++) begin : g_lane_chk
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lane_cnt[g*CNT_W +: CNT_W]) == CNT_MAX && !$past(win_start))
        |-> lane_cnt[g*CNT_W +: CNT_W] == CNT_MAX);
    a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && !win_start) |=> $stable(lane_cnt[g*CNT_W +: CNT_W]));
  end
endmodule

bind spike_winner_decoder swd_checker #(.NUM_NEURONS(NUM_NEURONS), .CNT_W(CNT_W)) u_swd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .win_start    (win_start),
  .win_end      (win_end),
  .win_open     (win_open),
  .result_valid (result_valid),
  .class_idx    (class_idx),
  .win_count    (win_count),
  .tie_flag     (tie_flag),
  .no_spike     (no_spike),
  .lane_cnt     (lane_cnt)
);

// File: tb/spike_winner_decoder_test.sv
module spike_winner_decoder_test;
  localparam int M  = 10;
  localparam int CW = 8;
  localparam int IW = $clog2(M);
  localparam int NV = 6;
  localparam int WLEN = 128;

  // per entry: spike count target for each neuron, neuron k in byte k
  localparam logic [M*8-1:0] TGT [NV] = '{
    {8'd0, 8'd5,  8'd0,  8'd0, 8'd0, 8'd0,  8'd40, 8'd0,  8'd7, 8'd1},
    {8'd0, 8'd0,  8'd0,  8'd0, 8'd0, 8'd0,  8'd0,  8'd0,  8'd0, 8'd0},
    {8'd0, 8'd0,  8'd20, 8'd3, 8'd0, 8'd0,  8'd0,  8'd20, 8'd0, 8'd9},
    {8'd128,8'd127,8'd127,8'd0,8'd12,8'd0,  8'd0,  8'd0,  8'd0, 8'd127},
    {8'd0, 8'd0,  8'd0,  8'd0, 8'd0, 8'd0,  8'd0,  8'd0,  8'd0, 8'd1},
    {8'd3, 8'd3,  8'd3,  8'd3, 8'd3, 8'd3,  8'd3,  8'd3,  8'd3, 8'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          win_start = 1'b0;
  logic          win_end = 1'b0;
  logic [M-1:0]  spikes = '0;
  logic          result_valid;
  logic [IW-1:0] class_idx;
  logic [CW-1:0] win_count;
  logic          tie_flag;
  logic          no_spike;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spike_winner_decoder #(.NUM_NEURONS(M), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
    .spikes(spikes), .result_valid(result_valid), .class_idx(class_idx),
    .win_count(win_count), .tie_flag(tie_flag), .no_spike(no_spike)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one window: neuron k fires in slots below its target
  task automatic run_window(input logic [M*8-1:0] tgt, input int len);
    for (int s = 0; s < len; s++) begin
      @(negedge clk);
      win_start = (s == 0);
      win_end   = (s == len - 1);
      for (int k = 0; k < M; k++) spikes[k] = (int'(tgt[k*8 +: 8]) > s);
    end
    @(negedge clk);
    win_start = 1'b0; win_end = 1'b0; spikes = '0;
  endtask

  task automatic expect_result(input string req, input int idx, input int cnt,
                               input int tie, input int none);
    check({req, " valid"}, int'(result_valid), 1);
    check({req, " class"}, int'(class_idx), idx);
    check({req, " count"}, int'(win_count), cnt);
    check({req, " tie"},   int'(tie_flag), tie);
    check({req, " silent"},int'(no_spike), none);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1 valid", int'(result_valid), 0);
    check("R1 class", int'(class_idx), 0);
    check("R1 count", int'(win_count), 0);
    check("R1 flags", int'(tie_flag) + int'(no_spike), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(result_valid), 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int best, bidx, hits;
      best = -1; bidx = 0; hits = 0;
      for (int k = M - 1; k >= 0; k--) begin
        int c;
        c = int'(TGT[v][k*8 +: 8]);
        if (c > WLEN) c = WLEN;
        if (c >= best) begin
          if (c == best) hits++; else hits = 1;
          best = c; bidx = k;
        end
      end
      run_window(TGT[v], WLEN);
      expect_result($sformatf("R2 R3 R4 R5 vec%0d", v), (best == 0) ? 0 : bidx, best,
                    (best > 0 && hits > 1) ? 1 : 0, (best == 0) ? 1 : 0);
      @(negedge clk);
      check("R7 strobe one cycle", int'(result_valid), 0);
      check("R7 result held", int'(class_idx), (best == 0) ? 0 : bidx);
    end

    // R6 saturation: neuron 4 fires in all 300 slots, neuron 1 in 100
    run_window({8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255, 8'd0, 8'd0, 8'd100, 8'd0}, 50);
    begin
      for (int s = 0; s < 300; s++) begin
        @(negedge clk);
        win_start = (s == 0);
        win_end   = (s == 299);
        spikes = '0;
        spikes[4] = 1'b1;
        spikes[1] = (s < 100);
      end
      @(negedge clk);
      win_start = 0; win_end = 0; spikes = '0;
      expect_result("R6 saturation", 4, 255, 0, 0);
    end

    // R8 idle spikes and stray end ignored
    @(negedge clk);
    spikes = '1;
    repeat (5) @(negedge clk);
    win_end = 1'b1;
    @(negedge clk);
    win_end = 1'b0;
    @(negedge clk);
    check("R8 stray end no strobe", int'(result_valid), 0);
    check("R8 stray end result held", int'(win_count), 255);
    spikes = '0;
    run_window({8'd0, 8'd0, 8'd0, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0}, 10);
    expect_result("R8 idle spikes ignored", 6, 3, 0, 0);

    // R9 one-slot window
    @(negedge clk);
    win_start = 1; win_end = 1; spikes = 10'b0000100000;
    @(negedge clk);
    win_start = 0; win_end = 0; spikes = '0;
    expect_result("R9 single slot", 5, 1, 0, 0);

    // R10 restart mid-window
    @(negedge clk);
    win_start = 1; spikes = 10'b0000000100;
    for (int s = 0; s < 9; s++) begin
      @(negedge clk);
      win_start = 0;
    end
    win_start = 1; spikes = 10'b0100000000;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      win_start = 0;
    end
    win_end = 1;
    @(negedge clk);
    win_end = 0; spikes = '0;
    expect_result("R10 restart", 8, 4, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule